// File: doc/BRIEF.md
# Selectable Bridging Fault Injector

This combinational wrapper is placed between two driven signal vectors and the logic they feed. It can emulate a short between one bit of the first vector and the same bit of the second vector. A run-time index picks the bit, and a mode code picks the logic-level bridge model: wired-AND, wired-OR, or one net overriding the other. A global enable removes the fault entirely, so one netlist can run fault-free and faulty passes.

Besides the two possibly corrupted vectors, the block drives an activation flag. The flag is high only when the bridge changes at least one of the two bridged bits on the present pattern. A test-generation or fault-grading environment can use it to tell whether a pattern excites the modelled defect at all.

Top module: `bridge_fault_inj`

## Requirements
- R1: With `enable_i` low, both outputs equal their inputs bit for bit and `bridge_active_o` is 0, for every mode and index.
- R2: With mode code 3'b000 (no fault), both outputs equal their inputs and `bridge_active_o` is 0.
- R3: With mode code 3'b001 (wired-AND) and enable high, bit `pair_sel_i` of both outputs equals the AND of the two input bits at that position.
- R4: With mode code 3'b010 (wired-OR) and enable high, bit `pair_sel_i` of both outputs equals the OR of the two input bits at that position.
- R5: With mode code 3'b011 (first net dominant) and enable high, bit `pair_sel_i` of `net_b_o` takes the value of `net_a_i` at that bit, and `net_a_o` equals `net_a_i`.
- R6: With mode code 3'b100 (second net dominant) and enable high, bit `pair_sel_i` of `net_a_o` takes the value of `net_b_i` at that bit, and `net_b_o` equals `net_b_i`.
- R7: Mode codes 3'b101, 3'b110 and 3'b111 behave exactly like 3'b000.
- R8: Every bit position other than `pair_sel_i` passes through unchanged in both vectors, in every mode.
- R9: `bridge_active_o` is 1 exactly when at least one of the two bridged output bits differs from its fault-free input bit. Under a bridging mode this happens when the two input bits at the index differ. For example, under wired-AND the first net shows the fault when it is 1 and the second net is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| net_a_i | input | W | Fault-free value of the first vector |
| net_b_i | input | W | Fault-free value of the second vector |
| pair_sel_i | input | IW | Bit position that is bridged |
| mode_i | input | 3 | Bridge model code |
| enable_i | input | 1 | Global fault enable |
| net_a_o | output | W | First vector as seen downstream |
| net_b_o | output | W | Second vector as seen downstream |
| bridge_active_o | output | 1 | Bridge changes a bit on this pattern |

## Verification
The checker assumes that every input is driven to a known 0 or 1. It skips its checks while any input is unknown, and the bench drives all inputs before the first evaluation. It also assumes that `pair_sel_i` lies below W. With the default width of 16 every index value is legal, and the bench draws indices modulo W. Random patterns cover all eight mode codes and both enable levels. Directed patterns cover the extreme indices and the four combinations of the two bridged bits.

// File: rtl/bridge_fault_inj.sv
module bridge_fault_inj #(
  parameter int W  = 16,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  net_a_i,
  input  logic [W-1:0]  net_b_i,
  input  logic [IW-1:0] pair_sel_i,
  input  logic [2:0]    mode_i,
  input  logic          enable_i,
  output logic [W-1:0]  net_a_o,
  output logic [W-1:0]  net_b_o,
  output logic          bridge_active_o
);
  localparam logic [2:0] MODE_NONE  = 3'b000;
  localparam logic [2:0] MODE_WAND  = 3'b001;
  localparam logic [2:0] MODE_WOR   = 3'b010;
  localparam logic [2:0] MODE_A_DOM = 3'b011;
  localparam logic [2:0] MODE_B_DOM = 3'b100;

  logic a_bit, b_bit, a_fault, b_fault, hit;

  assign hit   = enable_i && (32'(pair_sel_i) < W);
  assign a_bit = net_a_i[pair_sel_i];
  assign b_bit = net_b_i[pair_sel_i];

  always_comb begin
    a_fault = a_bit;
    b_fault = b_bit;
    case (mode_i)
      MODE_WAND:  begin a_fault = a_bit & b_bit; b_fault = a_bit & b_bit; end
      MODE_WOR:   begin a_fault = a_bit | b_bit; b_fault = a_bit | b_bit; end
      MODE_A_DOM: b_fault = a_bit;
      MODE_B_DOM: a_fault = b_bit;
      MODE_NONE:  ;
      default:    ;
    endcase
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    wire sel_here = hit && (32'(pair_sel_i) == i);
    assign net_a_o[i] = sel_here ? a_fault : net_a_i[i];
    assign net_b_o[i] = sel_here ? b_fault : net_b_i[i];
  end

  assign bridge_active_o = hit && ((a_fault ^ a_bit) | (b_fault ^ b_bit));
endmodule

// File: rtl/bridge_fault_inj_chk.sv
module bridge_fault_inj_chk #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input logic [W-1:0]  net_a_i,
  input logic [W-1:0]  net_b_i,
  input logic [IW-1:0] pair_sel_i,
  input logic [2:0]    mode_i,
  input logic          enable_i,
  input logic [W-1:0]  net_a_o,
  input logic [W-1:0]  net_b_o,
  input logic          bridge_active_o
);
  logic [W-1:0] diff_a, diff_b, mask;
  logic known;

  assign known  = !$isunknown({net_a_i, net_b_i, pair_sel_i, mode_i, enable_i});
  assign diff_a = net_a_o ^ net_a_i;
  assign diff_b = net_b_o ^ net_b_i;
  assign mask   = W'(1) << pair_sel_i;

  always_comb begin
    if (known) begin
      // R1
      pass_when_off_chk: assert (enable_i || (diff_a == '0 && diff_b == '0 && !bridge_active_o));
      // R8
      other_bits_kept_chk: assert (((diff_a | diff_b) & ~mask) == '0);
      // R9
      flag_matches_change_chk: assert (bridge_active_o == (((diff_a | diff_b) & mask) != '0));
      // R2 R7
      inert_codes_chk: assert (!(mode_i == 3'b000 || mode_i > 3'b100) || (diff_a == '0 && diff_b == '0));
      // R3 R4
      wired_equal_chk: assert (!(enable_i && (mode_i == 3'b001 || mode_i == 3'b010))
                               || ((net_a_o & mask) == ((net_b_o & mask))));
      // R3
      wand_never_raises_chk: assert (!(enable_i && mode_i == 3'b001) || ((net_a_o & ~net_a_i) == '0));
      // R4
      wor_never_lowers_chk: assert (!(enable_i && mode_i == 3'b010) || ((~net_a_o & net_a_i) == '0));
      // R5
      a_dom_chk: assert (!(enable_i && mode_i == 3'b011) || (diff_a == '0 && ((net_b_o & mask) == (net_a_i & mask))));
      // R6
      b_dom_chk: assert (!(enable_i && mode_i == 3'b100) || (diff_b == '0 && ((net_a_o & mask) == (net_b_i & mask))));
    end
  end
endmodule

bind bridge_fault_inj bridge_fault_inj_chk #(.W(W), .IW(IW)) chk_i (.*);

// File: tb/bridge_fault_inj_tb_top.sv
module bridge_fault_inj_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic [W-1:0] a_i, b_i, a_o, b_o;
  logic [IW-1:0] sel;
  logic [2:0] mode;
  logic en, act;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_fault_inj #(.W(W), .IW(IW)) dut_i (
    .net_a_i(a_i), .net_b_i(b_i), .pair_sel_i(sel), .mode_i(mode), .enable_i(en),
    .net_a_o(a_o), .net_b_o(b_o), .bridge_active_o(act));

  function automatic logic [2*W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input int s, input logic [2:0] m, input logic e);
    logic [W-1:0] ea = a, eb = b;
    logic x = a[s], y = b[s], fa = a[s], fb = b[s];
    if (e) begin
      if (m == 3'b001) begin fa = x & y; fb = x & y; end
      else if (m == 3'b010) begin fa = x | y; fb = x | y; end
      else if (m == 3'b011) fb = x;
      else if (m == 3'b100) fa = y;
      ea[s] = fa; eb[s] = fb;
    end
    return {ea, eb, (fa != x) || (fb != y)};
  endfunction

  function automatic string tag(input logic [2:0] m, input logic e);
    if (!e) return "R1";
    case (m)
      3'b000: return "R2";
      3'b001: return "R3";
      3'b010: return "R4";
      3'b011: return "R5";
      3'b100: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input int s,
                       input logic [2:0] m, input logic e, input string req);
    logic [2*W:0] exp;
    @(posedge clk);
    a_i = a; b_i = b; sel = IW'(s); mode = m; en = e;
    @(negedge clk);
    exp = model(a, b, s, m, e);
    n_chk++;
    if ({a_o, b_o, act} !== exp) begin
      n_fail++;
      $display("FAIL %s (R8 R9) a=%h b=%h act=%b expected a=%h b=%h act=%b",
               req, a_o, b_o, act, exp[2*W:W+1], exp[W:1], exp[0]);
    end
  endtask

  initial begin
    int seed = 1234;
    logic [31:0] r;
    a_i = '0; b_i = '0; sel = '0; mode = '0; en = 1'b0;
    void'($urandom(seed));
    apply(16'hA5C3, 16'h3C5A, 5, 3'b001, 1'b0, "R1");
    apply(16'hFFFF, 16'h0000, 0, 3'b000, 1'b1, "R2");
    for (int v = 0; v < 4; v++) begin
      apply(16'(v[1]), 16'(v[0]), 0, 3'b001, 1'b1, "R3 R9");
      apply(16'(v[1]) << 15, 16'(v[0]) << 15, 15, 3'b010, 1'b1, "R4 R9");
      apply(16'(v[1]) << 7, 16'(v[0]) << 7, 7, 3'b011, 1'b1, "R5 R9");
      apply(16'(v[1]) << 9, 16'(v[0]) << 9, 9, 3'b100, 1'b1, "R6 R9");
    end
    for (int m = 5; m < 8; m++) apply(16'hFF00, 16'h00FF, 8, 3'(m), 1'b1, "R7");
    apply(16'hFFFE, 16'h0001, 0, 3'b001, 1'b1, "R8");
    for (int k = 0; k < 3000; k++) begin
      r = $urandom;
      apply(16'($urandom), 16'($urandom), int'(r[3:0]), r[6:4], r[9:7] != 0, tag(r[6:4], r[9:7] != 0));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule